// File: doc/BRIEF.md
# Serial Camera Link Word Deframer

This block sits behind the double-data-rate input registers of a camera receiver. It runs entirely in the fast capture clock domain, which is 3.5 times the pixel clock. It takes four serial data lanes and one forwarded-clock lane. Each lane delivers two bits per fast cycle: the rising-edge sample is the earlier bit and the falling-edge sample the later one. Seven serial bits per lane make one word, so one word arrives every 3.5 fast cycles. In practice that means 32 bits in one pixel period and 24 in the next.

The forwarded-clock lane is sampled exactly like a data lane. Its 7-bit framing mark `1100011` shows where each word starts and ends. The block keeps a short bit history for every lane and tests both 7-bit windows that end in the current fast cycle against the mark. Once the mark has been seen at one bit alignment for four words in a row, the block locks to that alignment. It then emits one 28-bit word per pixel period with a single-cycle strobe, split into 24 pixel bits and four control flags.

The output is a continuous stream. It has a valid strobe but no ready input, so it cannot be back-pressured, and nothing is buffered. A consumer must accept every strobed word in the cycle it appears. A word whose framing mark is wrong is dropped, the lock is released, and the search starts again.

Top module: `lvdsdes_top`

## Requirements
- R1: For each lane L (0 to 3), the lane's 7 bits of a word occupy `out_word[7L+6:7L]`. The first bit received goes to bit 7L+6. Within a fast cycle, the rising-edge sample comes before the falling-edge sample.
- R2: `locked` rises after the mark `1100011` has been seen on the clock lane at the same bit alignment at the end of four consecutive words. The first strobed word is the fifth word of the stream.
- R3: `out_valid` is high only while `locked` is high. No word is output before lock.
- R4: While locked on a steady stream, `out_valid` is a single-cycle pulse per word. The gaps between pulses alternate between 3 and 4 fast cycles.
- R5: Lock is found for every one of the 7 possible bit offsets of the stream relative to the fast-cycle pairs. After lock, the words come out in order with none missing.
- R6: If the clock-lane window at the locked alignment does not match the mark, that word is not output and `locked` drops. Output resumes with the fifth word after the bad one.
- R7: `out_pixel` = `out_word[23:0]`, `out_dval` = bit 24, `out_lval` = bit 25, `out_fval` = bit 26, `out_spare` = bit 27.
- R8: A clock lane that never carries the mark keeps `locked` and `out_valid` low for the whole time it is applied.
- R9: After reset, `locked` and `out_valid` are low and `out_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast capture clock, 3.5x the pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_rise | input | 4 | Rising-edge sample per data lane (earlier bit) |
| data_fall | input | 4 | Falling-edge sample per data lane (later bit) |
| mark_rise | input | 1 | Rising-edge sample of the forwarded-clock lane |
| mark_fall | input | 1 | Falling-edge sample of the forwarded-clock lane |
| out_valid | output | 1 | One-cycle strobe per deframed word |
| out_word | output | 28 | Deframed word, held between strobes |
| out_pixel | output | 24 | Pixel data bits of the word |
| out_dval | output | 1 | Data-valid control flag |
| out_lval | output | 1 | Line-valid control flag |
| out_fval | output | 1 | Frame-valid control flag |
| out_spare | output | 1 | Spare control bit |
| locked | output | 1 | Word alignment acquired |

## Verification
Some properties are checked by assertions on every cycle. Strobes appear only under lock. No two word ends fall in adjacent cycles, and no two strobes either. A mismatch at the locked alignment always clears the lock, and lock is only ever set in a cycle that saw the mark.

Other behaviour can only be shown by the bench's scenarios: the exact word that comes out first, the bit placement and order inside each lane, the 3/4 alternation of the gaps, recovery at all seven skews, the exact words lost after a corrupted mark, and a mark-free clock lane never locking.

// File: rtl/lvdsdes_pkg.sv
package lvdsdes_pkg;
  localparam int unsigned SER_BITS = 7;
  localparam logic [SER_BITS-1:0] FRAME_MARK = 7'b1100011;
  localparam int unsigned CTRL_BITS = 4;
  typedef logic [$clog2(SER_BITS)-1:0] bitidx_t;
endpackage

// File: rtl/lvdsdes_lane_shift.sv
module lvdsdes_lane_shift
  import lvdsdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_bit,
  input  logic              fall_bit,
  output logic [SER_BITS:0] hist
);
  // hist[0] is the newest bit (falling sample); hist[SER_BITS] the oldest.
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[SER_BITS-2:0], rise_bit, fall_bit};
  end
endmodule

// File: rtl/lvdsdes_align.sv
module lvdsdes_align
  import lvdsdes_pkg::*;
#(
  parameter int unsigned LOCK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SER_BITS:0] mark_hist,
  output logic              word_end,
  output logic              sel_hi,
  output logic              word_ok,
  output logic              locked
);
  localparam int unsigned SW = $clog2(LOCK_WORDS + 1);
  localparam bitidx_t LAST = bitidx_t'(SER_BITS - 1);
  localparam bitidx_t WRAP = bitidx_t'(SER_BITS - 2);

  bitidx_t idx_r, idx_lo, idx_nx, cand_r, off_r, hit_idx;
  logic [SW-1:0] streak_r;
  logic m_hi, m_lo, hit, end_hi, end_lo, cend;

  // idx_r labels the bit in mark_hist[1]; mark_hist[0] carries idx_r+1.
  always_comb begin
    idx_lo   = (idx_r == LAST) ? '0 : idx_r + bitidx_t'(1);
    idx_nx   = (idx_r >= WRAP) ? idx_r - WRAP : idx_r + bitidx_t'(2);
    m_hi     = (mark_hist[SER_BITS:1] == FRAME_MARK);
    m_lo     = (mark_hist[SER_BITS-1:0] == FRAME_MARK);
    end_hi   = (idx_r == off_r);
    end_lo   = (idx_lo == off_r);
    word_end = locked & (end_hi | end_lo);
    sel_hi   = end_hi;
    word_ok  = end_hi ? m_hi : m_lo;
    hit      = m_hi | m_lo;
    hit_idx  = m_hi ? idx_r : idx_lo;
    cend     = (idx_r == cand_r) | (idx_lo == cand_r);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_r    <= WRAP;
      cand_r   <= '0;
      off_r    <= '0;
      streak_r <= '0;
      locked   <= 1'b0;
    end else begin
      idx_r <= idx_nx;
      if (locked) begin
        if (word_end && !word_ok) begin
          locked   <= 1'b0;
          streak_r <= '0;
        end
      end else if (hit) begin
        if (hit_idx == cand_r) begin
          streak_r <= streak_r + SW'(1);
          if (streak_r == SW'(LOCK_WORDS - 1)) begin
            locked <= 1'b1;
            off_r  <= cand_r;
          end
        end else begin
          cand_r   <= hit_idx;
          streak_r <= SW'(1);
        end
      end else if (cend) begin
        streak_r <= '0;
      end
    end
  end

  // R6: a wrong mark at the locked alignment clears the lock.
  assert_drop_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !word_ok) |=> !locked);
  // R4: word ends are never in adjacent cycles.
  assert_end_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> !word_end);
  // R2: lock is only taken in a cycle that saw the mark.
  assert_lock_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit));
endmodule

// File: rtl/lvdsdes_assemble.sv
module lvdsdes_assemble
  import lvdsdes_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned WORD_W = LANES * SER_BITS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0][SER_BITS:0]   lane_hist,
  input  logic                           word_end,
  input  logic                           sel_hi,
  input  logic                           word_ok,
  output logic                           out_valid,
  output logic [WORD_W-1:0]              out_word
);
  logic [WORD_W-1:0] word_nx;

  for (genvar l = 0; l < LANES; l++) begin : g_pick
    assign word_nx[l*SER_BITS +: SER_BITS] =
      sel_hi ? lane_hist[l][SER_BITS:1] : lane_hist[l][SER_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= word_end & word_ok;
      if (word_end && word_ok) out_word <= word_nx;
    end
  end

  // R4: each word is a one-cycle strobe.
  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/lvdsdes_top.sv
module lvdsdes_top
  import lvdsdes_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned LOCK_WORDS = 4,
  localparam int unsigned WORD_W    = LANES * SER_BITS,
  localparam int unsigned PIX_W     = WORD_W - CTRL_BITS
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic [LANES-1:0]  data_rise,
  input  logic [LANES-1:0]  data_fall,
  input  logic              mark_rise,
  input  logic              mark_fall,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [PIX_W-1:0]  out_pixel,
  output logic              out_dval,
  output logic              out_lval,
  output logic              out_fval,
  output logic              out_spare,
  output logic              locked
);
  logic [LANES-1:0][SER_BITS:0] lane_hist;
  logic [SER_BITS:0]            mark_hist;
  logic word_end, sel_hi, word_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lvdsdes_lane_shift u_shift (
      .clk(clk_fast), .rst_n(rst_n),
      .rise_bit(data_rise[l]), .fall_bit(data_fall[l]),
      .hist(lane_hist[l])
    );
  end

  lvdsdes_lane_shift u_mark_shift (
    .clk(clk_fast), .rst_n(rst_n),
    .rise_bit(mark_rise), .fall_bit(mark_fall),
    .hist(mark_hist)
  );

  lvdsdes_align #(.LOCK_WORDS(LOCK_WORDS)) u_align (
    .clk(clk_fast), .rst_n(rst_n), .mark_hist(mark_hist),
    .word_end(word_end), .sel_hi(sel_hi), .word_ok(word_ok), .locked(locked)
  );

  lvdsdes_assemble #(.LANES(LANES)) u_asm (
    .clk(clk_fast), .rst_n(rst_n), .lane_hist(lane_hist),
    .word_end(word_end), .sel_hi(sel_hi), .word_ok(word_ok),
    .out_valid(out_valid), .out_word(out_word)
  );

  assign out_pixel = out_word[PIX_W-1:0];
  assign out_dval  = out_word[PIX_W];
  assign out_lval  = out_word[PIX_W+1];
  assign out_fval  = out_word[PIX_W+2];
  assign out_spare = out_word[PIX_W+3];

  // R3: words only leave under lock.
  assert_valid_locked_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid |-> locked);
endmodule

// File: tb/lvdsdes_top_test.sv
module lvdsdes_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] data_rise = '0, data_fall = '0;
  logic mark_rise = 1'b0, mark_fall = 1'b0;
  logic out_valid, locked, out_dval, out_lval, out_fval, out_spare;
  logic [27:0] out_word;
  logic [23:0] out_pixel;

  always #5 clk = ~clk;

  lvdsdes_top uut (
    .clk_fast(clk), .rst_n(rst_n), .data_rise(data_rise), .data_fall(data_fall),
    .mark_rise(mark_rise), .mark_fall(mark_fall), .out_valid(out_valid),
    .out_word(out_word), .out_pixel(out_pixel), .out_dval(out_dval),
    .out_lval(out_lval), .out_fval(out_fval), .out_spare(out_spare), .locked(locked)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int cur_skew = 0, cur_corrupt = -1, cur_words = 30;
  bit cur_bad = 0;
  logic [27:0] rx [64];
  int rx_t [64];
  int rx_n = 0;
  bit lock_seen = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] wv(int k);
    logic [31:0] v;
    v = k * 32'h00493_5B7 + cur_skew * 32'h0111_111 + 32'h0A5C3E1;
    return v[27:0];
  endfunction

  function automatic logic sbit(int lane, int n);
    int m, k, j;
    logic [6:0] mk;
    logic [27:0] w;
    if (n < cur_skew) return 1'b0;
    m = n - cur_skew; k = m / 7; j = m % 7;
    if (k >= cur_words) return 1'b0;
    if (lane == 4) begin
      if (cur_bad) return (m % 2 == 0);
      mk = 7'b1100011;
      if (k == cur_corrupt) mk = ~mk;
      return mk[6-j];
    end
    w = wv(k);
    return w[lane*7 + 6 - j];   // R1: first bit to lane MSB
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (locked) lock_seen = 1;
      if (out_valid && rx_n < 64) begin
        rx[rx_n] = out_word; rx_t[rx_n] = cyc; rx_n++;
        chk(out_pixel == out_word[23:0] && out_dval == out_word[24] &&
            out_lval == out_word[25] && out_fval == out_word[26] &&
            out_spare == out_word[27], "R7", "field split", int'(out_word[27:24]),
            int'(out_word[27:24]));
      end
    end
  end

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; data_rise = '0; data_fall = '0; mark_rise = 0; mark_fall = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rx_n = 0; lock_seen = 0;
  endtask

  task automatic drive();
    int total;
    total = (cur_skew + 7 * cur_words) / 2 + 6;
    for (int t = 0; t < total; t++) begin
      @(posedge clk); #1;
      for (int l = 0; l < 4; l++) begin
        data_rise[l] = sbit(l, 2*t);
        data_fall[l] = sbit(l, 2*t + 1);
      end
      mark_rise = sbit(4, 2*t);
      mark_fall = sbit(4, 2*t + 1);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_seq(string req, int first, int skip_lo, int skip_hi);
    int k;
    bit ok;
    k = first; ok = 1;
    for (int i = 0; i < rx_n; i++) begin
      if (k >= skip_lo && k <= skip_hi) k = skip_hi + 1;
      if (rx[i] != wv(k)) begin
        ok = 0;
        chk(0, req, $sformatf("word %0d", i), int'(rx[i]), int'(wv(k)));
      end
      k++;
    end
    chk(ok, req, "word sequence", rx_n, rx_n);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(!locked, "R9", "locked after reset", locked, 0);
    chk(!out_valid, "R9", "valid after reset", out_valid, 0);
    chk(out_word == 0, "R9", "word after reset", int'(out_word), 0);

    // R5 / R1 / R2 / R4: sweep all skews
    for (int s = 0; s < 7; s++) begin
      cur_skew = s; cur_corrupt = -1; cur_bad = 0; cur_words = 30;
      do_reset();
      drive();
      chk(rx_n == 26, "R5", $sformatf("word count skew %0d", s), rx_n, 26);
      chk(rx_n > 0 && rx[0] == wv(4), "R2", "first word is fifth", int'(rx[0]), int'(wv(4)));
      check_seq("R1", 4, -1, -1);
      for (int i = 2; i < rx_n; i++) begin
        int g1, g0;
        g1 = rx_t[i] - rx_t[i-1]; g0 = rx_t[i-1] - rx_t[i-2];
        chk((g1 == 3 || g1 == 4) && g1 != g0, "R4", "strobe gap", g1, 7 - g0);
      end
      chk(lock_seen, "R3", "lock seen", lock_seen, 1);
    end

    // R6: corrupted mark on word 12
    cur_skew = 3; cur_corrupt = 12; cur_bad = 0; cur_words = 30;
    do_reset();
    drive();
    chk(rx_n == 21, "R6", "count after drop", rx_n, 21);
    check_seq("R6", 4, 12, 16);

    // R8: mark-free clock lane
    cur_skew = 0; cur_corrupt = -1; cur_bad = 1; cur_words = 30;
    do_reset();
    drive();
    chk(!lock_seen, "R8", "never locked", lock_seen, 0);
    chk(rx_n == 0, "R8", "no strobes", rx_n, 0);
    chk(rx_n == 0, "R3", "no words without lock", rx_n, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule